// File: doc/BRIEF.md
# Second-Order Recursive Sample Filter

This block is a second-order recursive (biquad) filter for a stream of signed samples. Each clock edge on which the valid qualifier is high, it takes one new input sample. It forms a weighted sum of that sample, the two previous inputs and the two previous outputs, and produces one output sample. All five weights are added, and that includes the two feedback terms. A designer who wants the usual subtracted feedback loads negated feedback weights.

Each weight arrives as a 16-bit two's-complement fraction: a sign bit followed by 15 fractional bits, so 0x4001 means 0.5 + 2^-15. A parameter can set the internal weight width below 16. In that case only the upper bits of each 16-bit value are used. The five products are summed at full precision with three guard bits, and the sum is shifted right to remove the fractional scaling. The result is clamped to the output range and registered. The registered output holds its value between valid samples.

Sample width and weight width are independent parameters. The active-low asynchronous reset clears the whole filter history and the output.

Top module: `biquad_iir`

## Requirements
- R1: While rst_ni is low, y_o and the four history registers (two past inputs, two past outputs) are zero, independent of the clock. After reset is released, the first result depends only on the new input.
- R2: On a valid edge the result is b0·x[n] + b1·x[n-1] + b2·x[n-2] + a1·y[n-1] + a2·y[n-2]. Both feedback products are added, not subtracted. The history then shifts: x[n-1] takes the new input, x[n-2] takes the old x[n-1], y[n-1] takes the new output and y[n-2] takes the old y[n-1].
- R3: Each 16-bit weight input is reduced to COEF_W bits by keeping bits [15:16-COEF_W] as a signed value. Dropped low bits have no effect on the result.
- R4: On edges with valid_i low, y_o and the whole history stay unchanged, whatever x_i does.
- R5: The full-precision sum is shifted right arithmetically by COEF_W-1 bits, so rounding is toward minus infinity. With an input of -1 and b0 = 0x4000, the output is -1.
- R6: A scaled sum above 2^(DATA_W-1)-1 produces that maximum, and one below -2^(DATA_W-1) produces that minimum. The clamped value is the one stored as y[n-1].
- R7: y_o changes only on the rising clock edge at which valid_i is high. Between that edge and the next valid edge it shows the result for the sample taken at that edge.
- R8: With b0 = 0x7F00, the other weights zero and the default widths, y_o equals floor(x·127/128). That is the input itself, or one below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies x_i on this edge |
| x_i | input | DATA_W | Signed input sample |
| b0_i | input | 16 | Weight of x[n], signed fraction |
| b1_i | input | 16 | Weight of x[n-1], signed fraction |
| b2_i | input | 16 | Weight of x[n-2], signed fraction |
| a1_i | input | 16 | Weight of y[n-1], signed fraction, added |
| a2_i | input | 16 | Weight of y[n-2], signed fraction, added |
| y_o | output | DATA_W | Registered, clamped output sample |

## Verification
The properties assume that valid_i and x_i are known at every sampled edge. They also assume that the weights stay constant while a sample is being taken, because the clamping checks relate the scaled sum to the next output. The stimulus changes weights only while valid_i is low and after every expected result has been compared. It varies x_i freely during idle cycles to show that those cycles leave no trace. Saturation is reached only through large weights and full-scale inputs, and the reference model predicts that clamping.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int NUM_TAPS  = 5;
  localparam int RAW_W     = 16;
  localparam int GUARD_W   = 3;

  // tap order shared by sample and weight arrays
  typedef enum logic [2:0] {
    TAP_X0 = 3'd0,
    TAP_X1 = 3'd1,
    TAP_X2 = 3'd2,
    TAP_Y1 = 3'd3,
    TAP_Y2 = 3'd4
  } tap_e;
endpackage

// File: rtl/biquad_coef_slice.sv
module biquad_coef_slice
  import biquad_pkg::*;
#(
  parameter int COEF_W = 8
) (
  input  logic [NUM_TAPS-1:0][RAW_W-1:0]  raw_i,
  output logic [NUM_TAPS-1:0][COEF_W-1:0] coef_o
);
  localparam int LSB = RAW_W - COEF_W;

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign coef_o[t] = raw_i[t][RAW_W-1:LSB];
  end
endmodule

// File: rtl/biquad_delay_line.sv
module biquad_delay_line #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] x_new_i,
  input  logic [DATA_W-1:0] y_new_i,
  output logic [DATA_W-1:0] x1_o,
  output logic [DATA_W-1:0] x2_o,
  output logic [DATA_W-1:0] y1_o,
  output logic [DATA_W-1:0] y2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_o <= '0;
      x2_o <= '0;
      y1_o <= '0;
      y2_o <= '0;
    end else if (shift_i) begin
      x1_o <= x_new_i;
      x2_o <= x1_o;
      y1_o <= y_new_i;
      y2_o <= y1_o;
    end
  end
endmodule

// File: rtl/biquad_mac.sv
module biquad_mac
  import biquad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input  logic [NUM_TAPS-1:0][DATA_W-1:0] smp_i,
  input  logic [NUM_TAPS-1:0][COEF_W-1:0] coef_i,
  output logic signed [ACC_W-1:0]         acc_o
);
  logic signed [PROD_W-1:0] prod [NUM_TAPS];

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_mul
    assign prod[t] = PROD_W'($signed(smp_i[t]) * $signed(coef_i[t]));
  end

  always_comb begin
    acc_o = '0;
    for (int t = 0; t < NUM_TAPS; t++) begin
      acc_o = acc_o + ACC_W'(prod[t]);
    end
  end
endmodule

// File: rtl/biquad_scale_sat.sv
module biquad_scale_sat
  import biquad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  localparam int ACC_W = DATA_W + COEF_W + GUARD_W
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [ACC_W-1:0] scaled_o,
  output logic [DATA_W-1:0]       sat_o
);
  localparam int FRAC = COEF_W - 1;
  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((longint'(1) <<< (DATA_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -ACC_W'(longint'(1) <<< (DATA_W-1));

  assign scaled_o = acc_i >>> FRAC;

  always_comb begin
    if (scaled_o > Y_MAX)      sat_o = Y_MAX[DATA_W-1:0];
    else if (scaled_o < Y_MIN) sat_o = Y_MIN[DATA_W-1:0];
    else                       sat_o = scaled_o[DATA_W-1:0];
  end
endmodule

// File: rtl/biquad_iir.sv
module biquad_iir
  import biquad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  localparam int ACC_W = DATA_W + COEF_W + GUARD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [15:0]       b0_i,
  input  logic [15:0]       b1_i,
  input  logic [15:0]       b2_i,
  input  logic [15:0]       a1_i,
  input  logic [15:0]       a2_i,
  output logic [DATA_W-1:0] y_o
);
  logic [NUM_TAPS-1:0][RAW_W-1:0]  raw_w;
  logic [NUM_TAPS-1:0][COEF_W-1:0] coef_w;
  logic [NUM_TAPS-1:0][DATA_W-1:0] smp_w;
  logic [DATA_W-1:0] x1_q, x2_q, y1_q, y2_q;
  logic [DATA_W-1:0] sat_w;
  logic [DATA_W-1:0] y_q;
  logic signed [ACC_W-1:0] acc_w;
  logic signed [ACC_W-1:0] scaled_w;

  assign raw_w[TAP_X0] = b0_i;
  assign raw_w[TAP_X1] = b1_i;
  assign raw_w[TAP_X2] = b2_i;
  assign raw_w[TAP_Y1] = a1_i;
  assign raw_w[TAP_Y2] = a2_i;

  assign smp_w[TAP_X0] = x_i;
  assign smp_w[TAP_X1] = x1_q;
  assign smp_w[TAP_X2] = x2_q;
  assign smp_w[TAP_Y1] = y1_q;
  assign smp_w[TAP_Y2] = y2_q;

  biquad_coef_slice #(.COEF_W(COEF_W)) u_slice (
    .raw_i  (raw_w),
    .coef_o (coef_w)
  );

  biquad_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mac (
    .smp_i  (smp_w),
    .coef_i (coef_w),
    .acc_o  (acc_w)
  );

  biquad_scale_sat #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_sat (
    .acc_i    (acc_w),
    .scaled_o (scaled_w),
    .sat_o    (sat_w)
  );

  biquad_delay_line #(.DATA_W(DATA_W)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (valid_i),
    .x_new_i (x_i),
    .y_new_i (sat_w),
    .x1_o    (x1_q),
    .x2_o    (x2_q),
    .y1_o    (y1_q),
    .y2_o    (y2_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      y_q <= '0;
    else if (valid_i) y_q <= sat_w;
  end

  assign y_o = y_q;
endmodule

// File: rtl/biquad_iir_chk.sv
module biquad_iir_chk #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  localparam int ACC_W = DATA_W + COEF_W + 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [DATA_W-1:0]       x_i,
  input logic [DATA_W-1:0]       y_o,
  input logic [DATA_W-1:0]       x1_q,
  input logic [DATA_W-1:0]       x2_q,
  input logic [DATA_W-1:0]       y1_q,
  input logic [DATA_W-1:0]       y2_q,
  input logic signed [ACC_W-1:0] scaled_w
);
  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((longint'(1) <<< (DATA_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -ACC_W'(longint'(1) <<< (DATA_W-1));

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (y_o == '0 && x1_q == '0 && x2_q == '0 && y1_q == '0 && y2_q == '0));

  p_x_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (x1_q == $past(x_i) && x2_q == $past(x1_q)));

  p_y_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> y2_q == $past(y1_q));

  p_hold_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));

  p_hold_hist_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(x1_q) && $stable(x2_q) && $stable(y1_q) && $stable(y2_q)));

  p_pass_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && scaled_w <= Y_MAX && scaled_w >= Y_MIN) |=> y_o == $past(scaled_w[DATA_W-1:0]));

  p_sat_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && scaled_w > Y_MAX) |=> y_o == Y_MAX[DATA_W-1:0]);

  p_sat_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && scaled_w < Y_MIN) |=> y_o == Y_MIN[DATA_W-1:0]);

  p_stored_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> y1_q == y_o);
endmodule

bind biquad_iir biquad_iir_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .x_i      (x_i),
  .y_o      (y_o),
  .x1_q     (x1_q),
  .x2_q     (x2_q),
  .y1_q     (y1_q),
  .y2_q     (y2_q),
  .scaled_w (scaled_w)
);

// File: tb/tb_biquad_iir.sv
`timescale 1ns/1ps
module tb_biquad_iir;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] x_i = '0;
  logic [15:0]   b0_i = '0, b1_i = '0, b2_i = '0, a1_i = '0, a2_i = '0;
  logic [DW-1:0] y_o;

  biquad_iir #(.DATA_W(DW), .COEF_W(CW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .b0_i(b0_i), .b1_i(b1_i), .b2_i(b2_i), .a1_i(a1_i), .a2_i(a2_i),
    .y_o(y_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct { int val; string req; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_err = 0;
  int cb0, cb1, cb2, ca1, ca2;
  int mx1, mx2, my1, my2;
  int last_exp = 0;

  function automatic int sx(logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int trunc_c(logic [15:0] c);
    logic signed [15:0] s;
    s = $signed(c);
    return int'(s >>> (16 - CW));
  endfunction

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model_step(int x);
    int acc, s, hi, lo;
    hi = (1 << (DW-1)) - 1;
    lo = -(1 << (DW-1));
    acc = cb0*x + cb1*mx1 + cb2*mx2 + ca1*my1 + ca2*my2;
    s = acc >>> (CW-1);
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    mx2 = mx1; mx1 = x;
    my2 = my1; my1 = s;
    return s;
  endfunction

  task automatic set_coefs(logic [15:0] b0, logic [15:0] b1, logic [15:0] b2,
                           logic [15:0] a1, logic [15:0] a2);
    @(negedge clk_i);
    b0_i = b0; b1_i = b1; b2_i = b2; a1_i = a1; a2_i = a2;
    cb0 = trunc_c(b0); cb1 = trunc_c(b1); cb2 = trunc_c(b2);
    ca1 = trunc_c(a1); ca2 = trunc_c(a2);
  endtask

  task automatic send(int x, string req);
    exp_t e;
    @(negedge clk_i);
    x_i = x[DW-1:0];
    valid_i = 1'b1;
    e.val = model_step(x);
    e.req = req;
    last_exp = e.val;
    exp_q.push_back(e);
    @(posedge clk_i);
    #2 valid_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_model();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0; last_exp = 0;
  endtask

  // monitor: compare each produced result with the scoreboard head
  initial begin
    forever begin
      logic v;
      exp_t e;
      @(posedge clk_i);
      v = valid_i && rst_ni;
      @(negedge clk_i);
      if (v) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected result", sx(y_o), 9999);
        end else begin
          e = exp_q.pop_front();
          check(e.req, sx(y_o), e.val);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    clear_model();
    cb0 = 0; cb1 = 0; cb2 = 0; ca1 = 0; ca2 = 0;
    repeat (3) @(negedge clk_i);
    check("R1 reset output", sx(y_o), 0);
    rst_ni = 1'b1;

    // R2 impulse, feed-forward only
    set_coefs(16'h4000, 16'h2000, 16'h1000, 16'h0000, 16'h0000);
    send(100, "R2 impulse n0");
    send(0, "R2 impulse n1");
    send(0, "R2 impulse n2");
    send(0, "R2 impulse n3");
    drain();

    // R2 step with added feedback
    set_coefs(16'h2000, 16'h0000, 16'h0000, 16'h6000, 16'hE000);
    for (int i = 0; i < 12; i++) send(40, "R2 step feedback");
    drain();

    // R1 reset mid-stream clears history
    @(negedge clk_i);
    rst_ni = 1'b0;
    #3 check("R1 async clear", sx(y_o), 0);
    clear_model();
    @(negedge clk_i);
    rst_ni = 1'b1;
    send(0, "R1 history cleared");
    send(0, "R1 history cleared n1");
    drain();

    // R4 idle cycles with changing input
    set_coefs(16'h4000, 16'h2000, 16'h0000, 16'h4000, 16'h0000);
    send(60, "R2 prime");
    send(-30, "R2 prime n1");
    drain();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      x_i = DW'(17 * i + 5);
      @(negedge clk_i);
      check("R4 hold while idle", sx(y_o), last_exp);
    end
    send(10, "R4 history untouched");
    drain();

    // R7 output changes only at the valid edge
    begin
      exp_t e;
      @(negedge clk_i);
      x_i = DW'(50);
      valid_i = 1'b1;
      e.val = model_step(50);
      e.req = "R7 result after edge";
      exp_q.push_back(e);
      #5 check("R7 no change before edge", sx(y_o), last_exp);
      last_exp = e.val;
      @(posedge clk_i);
      #2 valid_i = 1'b0;
      drain();
      repeat (2) @(negedge clk_i);
      check("R7 held after edge", sx(y_o), last_exp);
    end

    // R3 low weight bits dropped
    @(negedge clk_i); rst_ni = 1'b0; clear_model();
    @(negedge clk_i); rst_ni = 1'b1;
    set_coefs(16'h40FF, 16'h00FF, 16'h0000, 16'h0000, 16'h0000);
    send(100, "R3 truncated b0");
    send(64, "R3 truncated b1 zero");
    set_coefs(16'h81FF, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    send(64, "R3 negative truncated");
    drain();

    // R5 floor scaling
    set_coefs(16'h4000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    send(-1, "R5 floor of -0.5");
    send(3, "R5 floor of 1.5");
    send(-3, "R5 floor of -1.5");
    drain();

    // R8 near-unity pass-through
    set_coefs(16'h7F00, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    send(100, "R8 pass 100");
    send(-100, "R8 pass -100");
    send(1, "R8 pass 1");
    send(127, "R8 pass 127");
    send(-128, "R8 pass -128");
    drain();

    // R6 saturation, clamped value fed back
    set_coefs(16'h7F00, 16'h7F00, 16'h7F00, 16'h0000, 16'h0000);
    send(127, "R6 sat n0");
    send(127, "R6 sat high");
    send(127, "R6 sat high n2");
    send(-128, "R6 sat toward low");
    send(-128, "R6 sat low");
    send(-128, "R6 sat low n2");
    drain();
    set_coefs(16'h0000, 16'h0000, 16'h0000, 16'h4000, 16'h0000);
    send(0, "R6 stored clamp halves");
    send(0, "R6 stored clamp halves n1");
    drain();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule